// File: doc/BRIEF.md
# Grouped GPIO Interrupt Summary with End-of-Interrupt Rearm

This block sits between a bank of per-pin interrupt detectors and the single interrupt input of a host processor. It folds the per-pin request vector into a compact summary in which every bit stands for a group of four neighbouring pins. The summary is published as a pair of 32-bit words that software reads to find which groups need service. Pins are arranged as three banks of sixty-four slots. Only the first forty-six groups, covering pins 0 to 183, are reported. The summary bits above that always read zero.

The host line follows an arm/disarm scheme rather than the level of the requests. While the block is armed, any set summary bit raises the line, and the block then disarms. The line stays high, whatever the requests do, until software writes the master register with its end-of-interrupt bit (bit 29) set. That write drops the line for one cycle and rearms the block. If a request is still pending at that point, the line rises again on the following cycle, so a batch that arrived during service is not lost. The end-of-interrupt bit is a strobe with no storage behind it. Master writes without bit 29 have no effect.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n (for n from 0 to 45) is set exactly when at least one of pins 4n, 4n+1, 4n+2 and 4n+3 requests.
- R2: `sum_lo` carries summary bits 0 to 31 at bit positions 0 to 31. `sum_hi` carries summary bits 32 to 45 at bit positions 0 to 13.
- R3: Summary bits 46 to 63 (`sum_hi` bits 14 to 31) always read 0. Requests on pins 184 to 191 neither set a summary bit nor raise `host_irq`.
- R4: The summary is registered. A request present before a rising clock edge appears in the summary right after that edge.
- R5: While `host_irq` is low and no end-of-interrupt is being written, a non-zero summary raises `host_irq` at the next edge. The line never rises without a non-zero summary in the cycle before.
- R6: Once high, `host_irq` stays high until an end-of-interrupt write, even after every request has cleared.
- R7: An end-of-interrupt is a cycle with `mst_wr` high and `mst_wdata` bit 29 set. It clears `host_irq` at the next edge. A master write with bit 29 clear leaves `host_irq` unchanged.
- R8: If the summary is still non-zero when an end-of-interrupt is written, `host_irq` is low for exactly one cycle and then high again.
- R9: After an end-of-interrupt with no pending request, `host_irq` stays low until a new request arrives, and then rises again.
- R10: Synchronous active-low reset clears the summary and `host_irq` and leaves the block armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_req | input | 192 | Per-pin interrupt requests, one bit per pin slot |
| mst_wr | input | 1 | Master register write strobe |
| mst_wdata | input | 32 | Master register write data; bit 29 is end-of-interrupt |
| sum_lo | output | 32 | Summary bits 0 to 31 |
| sum_hi | output | 32 | Summary bits 32 to 63 (only bits 0 to 13 can be set) |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The assertions check the arm/disarm rules on every cycle:
- the line holds high until an end-of-interrupt;
- an end-of-interrupt always drops it;
- an armed block with a non-zero summary always raises it;
- it never rises without a pending summary;
- the unreported summary bits stay zero.

The bench's scenarios cover what the assertions cannot:
- the exact mapping of pin numbers to summary bits across the two words, including the group boundaries at bits 31/32 and 45/46;
- the one-cycle summary latency;
- the full sequence of service, rearm and re-raise with a request still pending.

// File: rtl/gis_pkg.sv
package gis_pkg;
   localparam int unsigned GIS_WORD_W    = 32;
   localparam int unsigned GIS_EOI_BIT   = 29;
   localparam int unsigned GIS_BANK_PINS = 64;
   localparam int unsigned GIS_NUM_BANKS = 3;
   localparam int unsigned GIS_GRP_SIZE  = 4;
   localparam int unsigned GIS_SUM_VALID = 46;

   typedef enum logic {
      GIS_ARMED   = 1'b0,
      GIS_WAITING = 1'b1
   } gis_arm_e;
endpackage

// File: rtl/gis_bank_or.sv
module gis_bank_or #(
   parameter int unsigned BANK_PINS = 64,
   parameter int unsigned GRP_SIZE  = 4,
   localparam int unsigned GRPS     = BANK_PINS / GRP_SIZE
) (
   input  logic [BANK_PINS-1:0] pins,
   output logic [GRPS-1:0]      grp_req
);
   generate
      if (BANK_PINS % GRP_SIZE != 0) begin : g_bad
         $error("gis_bank_or: bank size must be a multiple of the group size");
      end
      for (genvar g = 0; g < GRPS; g++) begin : g_grp
         assign grp_req[g] = |pins[g*GRP_SIZE +: GRP_SIZE];
      end
   endgenerate
endmodule

// File: rtl/gis_summary.sv
module gis_summary #(
   parameter int unsigned NUM_GROUPS = 48,
   parameter int unsigned SUM_VALID  = 46,
   parameter int unsigned SUM_W      = 64,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_GROUPS-1:0] grp_req,
   output logic [SUM_W-1:0]      summary
);
   logic [SUM_W-1:0] sum_d;

   generate
      if (SUM_VALID > NUM_GROUPS || NUM_GROUPS > SUM_W) begin : g_bad
         $error("gis_summary: inconsistent group counts");
      end
      for (genvar i = 0; i < SUM_W; i++) begin : g_bit
         if (i < SUM_VALID) begin : g_live
            assign sum_d[i] = grp_req[i];
         end else begin : g_zero
            assign sum_d[i] = 1'b0;
         end
      end
      if (NUM_GROUPS > SUM_VALID) begin : g_drop
         logic unused_grp;
         assign unused_grp = |grp_req[NUM_GROUPS-1:SUM_VALID];
      end
      if (REGISTERED) begin : g_reg
         logic [SUM_W-1:0] sum_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sum_q <= '0;
            else        sum_q <= sum_d;
         end
         assign summary = sum_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign summary    = sum_d;
      end
   endgenerate

   // R3: unreported groups never appear in the summary
   p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      summary[SUM_W-1:SUM_VALID] == '0);
endmodule

// File: rtl/gis_arm.sv
module gis_arm
   import gis_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned EOI_BIT = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              any_req,
   output logic              irq
);
   gis_arm_e state_q;
   logic     eoi;
   logic     unused_wdata;

   generate
      if (EOI_BIT >= WORD_W) begin : g_bad
         $error("gis_arm: end-of-interrupt bit outside the master word");
      end
   endgenerate

   assign eoi          = wr & wdata[EOI_BIT];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GIS_ARMED;
      end else if (eoi) begin
         state_q <= GIS_ARMED;
      end else if (state_q == GIS_ARMED && any_req) begin
         state_q <= GIS_WAITING;
      end
   end

   assign irq = (state_q == GIS_WAITING);

   // R6: line holds until end-of-interrupt
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !eoi |=> irq);
   // R7: end-of-interrupt always drops the line
   p_eoi_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> !irq);
   // R5: armed block with pending summary raises the line
   p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && any_req && !eoi |=> irq);
   // R5: no rise without a pending summary
   p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(any_req));
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
   import gis_pkg::*;
#(
   parameter int unsigned BANK_PINS = GIS_BANK_PINS,
   parameter int unsigned NUM_BANKS = GIS_NUM_BANKS,
   parameter int unsigned GRP_SIZE  = GIS_GRP_SIZE,
   parameter int unsigned SUM_VALID = GIS_SUM_VALID,
   parameter int unsigned WORD_W    = GIS_WORD_W,
   parameter int unsigned EOI_BIT   = GIS_EOI_BIT,
   parameter bit          SUM_REG   = 1'b1,
   localparam int unsigned NUM_PINS  = BANK_PINS * NUM_BANKS,
   localparam int unsigned BANK_GRPS = BANK_PINS / GRP_SIZE,
   localparam int unsigned NUM_GRPS  = BANK_GRPS * NUM_BANKS,
   localparam int unsigned SUM_W     = 2 * WORD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_req,
   input  logic                mst_wr,
   input  logic [WORD_W-1:0]   mst_wdata,
   output logic [WORD_W-1:0]   sum_lo,
   output logic [WORD_W-1:0]   sum_hi,
   output logic                host_irq
);
   logic [NUM_GRPS-1:0] grp_req;
   logic [SUM_W-1:0]    summary;

   generate
      if (NUM_GRPS > SUM_W) begin : g_bad_w
         $error("gpio_irq_summary: more groups than summary bits");
      end
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         gis_bank_or #(
            .BANK_PINS (BANK_PINS),
            .GRP_SIZE  (GRP_SIZE)
         ) u_bank (
            .pins    (pin_req[b*BANK_PINS +: BANK_PINS]),
            .grp_req (grp_req[b*BANK_GRPS +: BANK_GRPS])
         );
      end
   endgenerate

   gis_summary #(
      .NUM_GROUPS (NUM_GRPS),
      .SUM_VALID  (SUM_VALID),
      .SUM_W      (SUM_W),
      .REGISTERED (SUM_REG)
   ) u_sum (
      .clk     (clk),
      .rst_n   (rst_n),
      .grp_req (grp_req),
      .summary (summary)
   );

   gis_arm #(
      .WORD_W  (WORD_W),
      .EOI_BIT (EOI_BIT)
   ) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (mst_wr),
      .wdata   (mst_wdata),
      .any_req (|summary),
      .irq     (host_irq)
   );

   assign sum_lo = summary[WORD_W-1:0];
   assign sum_hi = summary[SUM_W-1:WORD_W];

   // R10: reset leaves the line low on the following cycle
   p_reset_r10: assert property (@(posedge clk)
      !rst_n |=> !host_irq);
endmodule

// File: tb/gpio_irq_summary_tb.sv
module gpio_irq_summary_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [191:0] pin_req = '0;
   logic         mst_wr = 1'b0;
   logic [31:0]  mst_wdata = '0;
   logic [31:0]  sum_lo, sum_hi;
   logic         host_irq;
   int           n_chk = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_summary u_dut (
      .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .mst_wr(mst_wr),
      .mst_wdata(mst_wdata), .sum_lo(sum_lo), .sum_hi(sum_hi),
      .host_irq(host_irq)
   );

   localparam int NV = 10;
   localparam logic [191:0] PAT [NV] = '{
      192'd1,                         // R1 pin 0
      192'd1 << 7,                    // R1 pin 7 -> bit 1
      192'hF0,                        // R1 pins 4..7 -> bit 1
      192'd1 << 127,                  // R2 bit 31
      192'd1 << 128,                  // R2 bit 32
      192'd1 << 183,                  // R2 bit 45
      192'd1 << 184,                  // R3 dropped
      {8'hFF, 184'd0},                // R3 pins 184..191
      {192{1'b1}},                    // R1 all
      (192'd1 << 40) | (192'd1 << 70) // R1 bits 10 and 17
   };
   localparam logic [63:0] EXP [NV] = '{
      64'h1, 64'h2, 64'h2, 64'h8000_0000, 64'h1_0000_0000,
      64'h0000_2000_0000_0000, 64'h0, 64'h0,
      64'h0000_3FFF_FFFF_FFFF, 64'h0000_0000_0002_0400
   };

   task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s summary act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk1(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s host_irq act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pin_req = '0;
      mst_wr = 1'b0;
      tick();
      rst_n = 1'b1;
   endtask

   task automatic master_write(logic [31:0] d);
      mst_wr = 1'b1;
      mst_wdata = d;
      tick();
      mst_wr = 1'b0;
      mst_wdata = '0;
   endtask

   initial begin
      do_reset();
      chk64("R10", {sum_hi, sum_lo}, 64'h0);
      chk1("R10", host_irq, 1'b0);

      // table walk: summary one edge after driving the pins
      for (int i = 0; i < NV; i++) begin
         pin_req = PAT[i];
         tick();
         chk64(i < 3 ? "R1/R4" : (i < 6 ? "R2" : (i < 8 ? "R3" : "R1")),
               {sum_hi, sum_lo}, EXP[i]);
      end

      // R4 latency and R5 raise
      do_reset();
      pin_req = 192'd1 << 9;
      tick();
      chk64("R4", {sum_hi, sum_lo}, 64'h4);
      chk1("R5", host_irq, 1'b0);
      tick();
      chk1("R5", host_irq, 1'b1);

      // R6 hold after requests clear
      pin_req = '0;
      tick(); tick(); tick();
      chk64("R6", {sum_hi, sum_lo}, 64'h0);
      chk1("R6", host_irq, 1'b1);

      // R7 write without bit 29 has no effect
      master_write(32'hDFFF_FFFF);
      tick();
      chk1("R7", host_irq, 1'b1);

      // R7/R9 end-of-interrupt with nothing pending
      master_write(32'h2000_0000);
      chk1("R7", host_irq, 1'b0);
      tick(); tick();
      chk1("R9", host_irq, 1'b0);

      // R9 new request rearms the line
      pin_req = 192'd1 << 20;
      tick(); tick();
      chk1("R9", host_irq, 1'b1);

      // R8 end-of-interrupt with request still pending
      master_write(32'h2000_0000);
      chk1("R8", host_irq, 1'b0);
      tick();
      chk1("R8", host_irq, 1'b1);

      // R3 unreported pins never raise the line
      pin_req = '0;
      tick();
      master_write(32'h2000_0000);
      pin_req = 192'd1 << 190;
      tick(); tick(); tick();
      chk64("R3", {sum_hi, sum_lo}, 64'h0);
      chk1("R3", host_irq, 1'b0);

      // R10 reset mid-service
      pin_req = 192'd1 << 2;
      tick(); tick();
      do_reset();
      chk1("R10", host_irq, 1'b0);
      chk64("R10", {sum_hi, sum_lo}, 64'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule